// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block supplies addresses for indirect memory accesses. Each pointer lives in a register set, not in the instruction. There are two banks of register sets, primary and secondary. Each set holds four registers: an index pointer, a signed modify step, a buffer length and a base address. When an access is requested, the block returns the current index of the chosen set as the address. In the same cycle it post-modifies that index by the step and folds the result back inside the buffer `[base, base+length)`. The wrap costs no extra cycle, and the buffer bounds need no alignment.

Software-side logic loads the registers through a write port and reads them back through a combinational read port. A bank-select level chooses the bank for accesses, writes and reads alike. Switching banks leaves the contents of both banks untouched, so up to 32 buffers stay live at the same time.

Top module: `circ_addr_gen`

## Requirements
- R1: Reset (asynchronous, active low) clears every register of both banks to zero and drives `addr_vld` low.
- R2: A write with `wr_en` high updates register `wr_field` of set `wr_set` in the bank picked by `bank_sel`. The field codes are 0 for index, 1 for modify, 2 for length and 3 for base. `rd_data` shows field `rd_field` of set `rd_set` in the selected bank, in the same cycle.
- R3: Writing the base register also loads the index register of that set with the written value.
- R4: One cycle after a clock edge with `acc_vld` high, `addr_vld` is high and `acc_addr` equals the index that set `acc_set` held before the access. After an edge with `acc_vld` low, `addr_vld` is low.
- R5: An access sets the index to index + modify when that sum stays inside `[base, base+length)`. The modify value is 32-bit two's complement.
- R6: If index + modify reaches or passes base + length, the length is subtracted from it.
- R7: If index + modify falls below base, the length is added to it.
- R8: A length of 0 disables wrapping. The index then steps linearly, modulo 2^32.
- R9: `bank_sel` at 0 chooses the primary bank and at 1 the secondary bank. Sets in the bank that is not selected keep their values.
- R10: When a write and an access hit the same set in the same cycle:
  - the address is the old index;
  - a write to index or base overrides the post-modify result;
  - the post-modify uses the modify and length values from before the write.
- R11: Accesses on consecutive cycles each produce one address, with no stall cycles, including when the index wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | 0 = primary bank, 1 = secondary bank |
| acc_vld | input | 1 | Access request |
| acc_set | input | 4 | Register set used by the access |
| addr_vld | output | 1 | Address output valid |
| acc_addr | output | 32 | Pre-modify address |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | 4 | Set written |
| wr_field | input | 2 | Field written (0 index, 1 modify, 2 length, 3 base) |
| wr_data | input | 32 | Write data |
| rd_set | input | 4 | Set read |
| rd_field | input | 2 | Field read |
| rd_data | output | 32 | Read data |

## Verification
A register write and an access can land on the same set in the same clock edge, and each contends for the index register. The bench provokes this by driving `wr_en` and `acc_vld` together on one set, once with an index write, once with a base write and once with a modify write. It then judges two things. The emitted address must be the old index, compared through the scoreboard. The stored index is read back and must be the written value, or the post-modify result computed with the old step.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
  typedef enum logic [1:0] {
    FLD_IDX  = 2'd0,
    FLD_MOD  = 2'd1,
    FLD_LEN  = 2'd2,
    FLD_BASE = 2'd3
  } fld_e;
endpackage

// File: rtl/cbag_wrap.sv
// Post-modify with circular fold; purely combinational.
module cbag_wrap #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] nxt
);
  localparam int unsigned XW = AW + 2;

  logic [AW-1:0]        off;
  logic signed [XW-1:0] sum;
  logic signed [XW-1:0] lenx;
  logic signed [XW-1:0] adj;

  always_comb begin
    off  = ptr - base;
    sum  = $signed({2'b00, off}) + $signed({{2{step[AW-1]}}, step});
    lenx = $signed({2'b00, len});
    adj  = sum;
    if (len != '0) begin
      if (sum >= lenx)
        adj = sum - lenx;
      else if (sum < 0)
        adj = sum + lenx;
    end
    nxt = base + adj[AW-1:0];
  end
endmodule

// File: rtl/cbag_regset.sv
// One register set: index, modify, length, base.
module cbag_regset
  import cbag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  fld_e          wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_ptr,
  output logic [AW-1:0] idx_q,
  output logic [AW-1:0] mod_q,
  output logic [AW-1:0] len_q,
  output logic [AW-1:0] base_q
);
  logic [AW-1:0] idx_d, mod_d, len_d, base_d;
  logic          idx_ce, mod_ce, len_ce, base_ce;

  always_comb begin
    idx_d   = idx_q;
    mod_d   = mod_q;
    len_d   = len_q;
    base_d  = base_q;
    idx_ce  = 1'b0;
    mod_ce  = 1'b0;
    len_ce  = 1'b0;
    base_ce = 1'b0;
    if (upd_en) begin
      idx_d  = upd_ptr;
      idx_ce = 1'b1;
    end
    if (wr_en) begin
      unique case (wr_field)
        FLD_IDX: begin
          idx_d  = wr_data;
          idx_ce = 1'b1;
        end
        FLD_MOD: begin
          mod_d  = wr_data;
          mod_ce = 1'b1;
        end
        FLD_LEN: begin
          len_d  = wr_data;
          len_ce = 1'b1;
        end
        FLD_BASE: begin
          base_d  = wr_data;
          base_ce = 1'b1;
          idx_d   = wr_data;
          idx_ce  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mod_q  <= '0;
      len_q  <= '0;
      base_q <= '0;
    end else begin
      if (idx_ce)  idx_q  <= idx_d;
      if (mod_ce)  mod_q  <= mod_d;
      if (len_ce)  len_q  <= len_d;
      if (base_ce) base_q <= base_d;
    end
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cbag_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NSETS = 16,
  localparam int unsigned SW   = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_sel,
  input  logic          acc_vld,
  input  logic [SW-1:0] acc_set,
  output logic          addr_vld,
  output logic [AW-1:0] acc_addr,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  logic [1:0]    wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic [SW-1:0] rd_set,
  input  logic [1:0]    rd_field,
  output logic [AW-1:0] rd_data
);
  localparam int unsigned NTOT = 2 * NSETS;
  localparam int unsigned TW   = SW + 1;

  logic [AW-1:0] idx_a  [NTOT];
  logic [AW-1:0] mod_a  [NTOT];
  logic [AW-1:0] len_a  [NTOT];
  logic [AW-1:0] base_a [NTOT];

  logic [TW-1:0] acc_sel, wr_sel, rd_sel;
  logic [AW-1:0] cur_idx, cur_mod, cur_len, cur_base, nxt_ptr;
  logic          addr_vld_d;
  logic [AW-1:0] acc_addr_d;
  fld_e          wr_fld;

  assign acc_sel = {bank_sel, acc_set};
  assign wr_sel  = {bank_sel, wr_set};
  assign rd_sel  = {bank_sel, rd_set};
  assign wr_fld  = fld_e'(wr_field);

  assign cur_idx  = idx_a[acc_sel];
  assign cur_mod  = mod_a[acc_sel];
  assign cur_len  = len_a[acc_sel];
  assign cur_base = base_a[acc_sel];

  cbag_wrap #(.AW(AW)) u_wrap (
    .ptr  (cur_idx),
    .step (cur_mod),
    .len  (cur_len),
    .base (cur_base),
    .nxt  (nxt_ptr)
  );

  for (genvar g = 0; g < NTOT; g++) begin : g_set
    cbag_regset #(.AW(AW)) u_set (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_sel == TW'(g))),
      .wr_field (wr_fld),
      .wr_data  (wr_data),
      .upd_en   (acc_vld && (acc_sel == TW'(g))),
      .upd_ptr  (nxt_ptr),
      .idx_q    (idx_a[g]),
      .mod_q    (mod_a[g]),
      .len_q    (len_a[g]),
      .base_q   (base_a[g])
    );
  end

  always_comb begin
    unique case (fld_e'(rd_field))
      FLD_IDX:  rd_data = idx_a[rd_sel];
      FLD_MOD:  rd_data = mod_a[rd_sel];
      FLD_LEN:  rd_data = len_a[rd_sel];
      FLD_BASE: rd_data = base_a[rd_sel];
      default:  rd_data = '0;
    endcase
  end

  always_comb begin
    addr_vld_d = acc_vld;
    acc_addr_d = acc_vld ? cur_idx : acc_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_vld <= 1'b0;
      acc_addr <= '0;
    end else begin
      addr_vld <= addr_vld_d;
      acc_addr <= acc_addr_d;
    end
  end
endmodule

// File: rtl/cbag_chk.sv
module cbag_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_vld,
  input logic          wr_en,
  input logic          bank_sel,
  input logic [SW-1:0] rd_set,
  input logic [1:0]    rd_field,
  input logic [AW-1:0] rd_data,
  input logic          addr_vld,
  input logic [AW-1:0] acc_addr,
  input logic [AW-1:0] cur_idx,
  input logic [AW-1:0] cur_mod,
  input logic [AW-1:0] cur_len,
  input logic [AW-1:0] cur_base,
  input logic [AW-1:0] nxt_ptr
);
  logic [AW-1:0] step_mag;
  assign step_mag = cur_mod[AW-1] ? (~cur_mod + 1'b1) : cur_mod;

  // R4
  addr_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> addr_vld);

  // R4
  addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !addr_vld);

  // R4
  addr_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> acc_addr == $past(cur_idx));

  // R6
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && cur_len != '0 && (cur_idx - cur_base) < cur_len && step_mag <= cur_len)
      |-> (nxt_ptr - cur_base) < cur_len);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(acc_vld) && $stable(bank_sel) && $stable(rd_set)
     && $stable(rd_field)) |-> $stable(rd_data));
endmodule

bind circ_addr_gen cbag_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_vld  (acc_vld),
  .wr_en    (wr_en),
  .bank_sel (bank_sel),
  .rd_set   (rd_set),
  .rd_field (rd_field),
  .rd_data  (rd_data),
  .addr_vld (addr_vld),
  .acc_addr (acc_addr),
  .cur_idx  (cur_idx),
  .cur_mod  (cur_mod),
  .cur_len  (cur_len),
  .cur_base (cur_base),
  .nxt_ptr  (nxt_ptr)
);

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;
  localparam int AW = 32;
  localparam int SW = 4;

  logic          clk, rst_n, bank_sel, acc_vld, wr_en;
  logic [SW-1:0] acc_set, wr_set, rd_set;
  logic [1:0]    wr_field, rd_field;
  logic [AW-1:0] wr_data, rd_data, acc_addr;
  logic          addr_vld;

  int n_run = 0;
  int n_fail = 0;
  logic [AW-1:0] exp_q [$];
  string         tag_q [$];

  logic [AW-1:0] m_reg [2][16][4];

  circ_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .acc_vld(acc_vld),
    .acc_set(acc_set), .addr_vld(addr_vld), .acc_addr(acc_addr),
    .wr_en(wr_en), .wr_set(wr_set), .wr_field(wr_field), .wr_data(wr_data),
    .rd_set(rd_set), .rd_field(rd_field), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] model_next(logic [AW-1:0] p, logic [AW-1:0] m,
                                               logic [AW-1:0] l, logic [AW-1:0] b);
    longint off, s;
    off = longint'(p - b);
    s = off + longint'($signed(m));
    if (l != 0) begin
      if (s >= longint'(l)) s = s - longint'(l);
      else if (s < 0) s = s + longint'(l);
    end
    return b + s[AW-1:0];
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock of stimulus; the model is updated with the same rules.
  task automatic step(input logic bk, input logic acc, input int aset,
                      input logic wr, input int wset, input int fld,
                      input logic [AW-1:0] data, input string tag);
    logic [AW-1:0] np;
    @(negedge clk);
    bank_sel = bk; acc_vld = acc; acc_set = SW'(aset);
    wr_en = wr; wr_set = SW'(wset); wr_field = 2'(fld); wr_data = data;
    if (acc) begin
      exp_q.push_back(m_reg[bk][aset][0]);
      tag_q.push_back(tag);
      np = model_next(m_reg[bk][aset][0], m_reg[bk][aset][1],
                      m_reg[bk][aset][2], m_reg[bk][aset][3]);
      m_reg[bk][aset][0] = np;
    end
    if (wr) begin
      m_reg[bk][wset][fld] = data;
      if (fld == 3) m_reg[bk][wset][0] = data;
    end
  endtask

  task automatic idle();
    step(bank_sel, 1'b0, 0, 1'b0, 0, 0, '0, "");
  endtask

  task automatic wreg(input logic bk, input int s, input int f, input logic [AW-1:0] d);
    step(bk, 1'b0, 0, 1'b1, s, f, d, "R2");
  endtask

  task automatic rchk(input logic bk, input int s, input int f, input string req);
    @(negedge clk);
    acc_vld = 1'b0; wr_en = 1'b0;
    bank_sel = bk; rd_set = SW'(s); rd_field = 2'(f);
    #1;
    check(req, rd_data, m_reg[bk][s][f]);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && addr_vld) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R4 actual=%h expected=<none>", acc_addr);
      end else begin
        automatic logic [AW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, acc_addr, e);
      end
    end
  end

  initial begin
    #1500000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++)
        for (int f = 0; f < 4; f++) m_reg[b][s][f] = '0;
    rst_n = 1'b0; bank_sel = 0; acc_vld = 0; acc_set = 0; wr_en = 0;
    wr_set = 0; wr_field = 0; wr_data = 0; rd_set = 0; rd_field = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", {31'd0, addr_vld}, 32'd0);
    rst_n = 1'b1;
    rchk(0, 3, 0, "R1");
    rchk(1, 9, 3, "R1");

    // R2/R3: field writes and readback
    wreg(0, 3, 3, 32'd100);
    rchk(0, 3, 0, "R3");
    wreg(0, 3, 2, 32'd10);
    wreg(0, 3, 1, 32'd3);
    rchk(0, 3, 1, "R2");
    rchk(0, 3, 2, "R2");

    // R5/R6/R11: back-to-back with upward wrap
    for (int i = 0; i < 5; i++) step(0, 1, 3, 0, 0, 0, '0, "R6");
    idle();
    rchk(0, 3, 0, "R6");

    // R7: negative step below base
    wreg(0, 5, 3, 32'd200);
    wreg(0, 5, 2, 32'd7);
    wreg(0, 5, 1, 32'hFFFF_FFFD);
    for (int i = 0; i < 4; i++) step(0, 1, 5, 0, 0, 0, '0, "R7");
    idle();
    rchk(0, 5, 0, "R7");

    // R8: length zero, linear roll-over
    wreg(0, 7, 3, 32'hFFFF_FFFE);
    wreg(0, 7, 1, 32'd1);
    for (int i = 0; i < 3; i++) step(0, 1, 7, 0, 0, 0, '0, "R8");
    idle();
    rchk(0, 7, 0, "R8");

    // R5: step equal to length keeps pointer; in-range step
    wreg(0, 8, 3, 32'd40);
    wreg(0, 8, 2, 32'd5);
    wreg(0, 8, 1, 32'd5);
    step(0, 1, 8, 0, 0, 0, '0, "R5");
    step(0, 1, 8, 0, 0, 0, '0, "R5");
    idle();
    rchk(0, 8, 0, "R5");

    // R9: secondary bank, same set number
    wreg(1, 3, 3, 32'd500);
    wreg(1, 3, 2, 32'd4);
    wreg(1, 3, 1, 32'd1);
    step(1, 1, 3, 0, 0, 0, '0, "R9");
    step(1, 1, 3, 0, 0, 0, '0, "R9");
    step(0, 1, 3, 0, 0, 0, '0, "R9");
    step(1, 1, 3, 0, 0, 0, '0, "R9");
    idle();
    rchk(1, 3, 0, "R9");
    rchk(0, 3, 0, "R9");
    rchk(0, 3, 1, "R9");

    // R10: write and access on the same set in one cycle
    step(0, 1, 3, 1, 3, 0, 32'd105, "R10");
    idle();
    rchk(0, 3, 0, "R10");
    step(0, 1, 3, 1, 3, 1, 32'd2, "R10");
    idle();
    rchk(0, 3, 0, "R10");
    rchk(0, 3, 1, "R10");
    step(0, 1, 3, 1, 3, 3, 32'd90, "R10");
    step(0, 1, 3, 0, 0, 0, '0, "R10");
    idle();
    rchk(0, 3, 0, "R10");

    repeat (3) idle();
    check("R4", 32'(exp_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule